// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Updates

This block controls a bank of 32 general-purpose pins from a small word-addressed register bus. Software sets a direction per pin and an output level per pin. Each pin also has an input path, which is synchronized and gated by a per-pin digital-enable signal before software reads it.

Besides the plain read-write output register, three write-only alias words update the output register in a single bus write, so no read-modify-write is needed. Each bit written as 1 is set, cleared or inverted, depending on the alias used. Bits written as 0 keep their value. This lets separate pieces of software own different pins without racing each other.

The bus uses word indices, not byte offsets:

| Word index | Byte offset | Register |
|---|---|---|
| 0 | 0x00 | output data |
| 1 | 0x04 | set alias |
| 2 | 0x08 | clear alias |
| 3 | 0x0C | toggle alias |
| 4 | 0x10 | input data |
| 5 | 0x14 | direction |
| 6, 7 | — | unmapped |

Register updates take effect on the rising edge of the write cycle. Read data is combinational.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset, the output-data and direction registers are zero, and so are `pin_out` and `pin_oe`.
- R2: A write to word 0 loads the whole output-data register. A read of word 0 returns it.
- R3: A write to word 1 (set alias) forces to 1 each output bit whose write-data bit is 1. The other bits are unchanged.
- R4: A write to word 2 (clear alias) forces to 0 each output bit whose write-data bit is 1. The other bits are unchanged.
- R5: A write to word 3 (toggle alias) inverts each output bit whose write-data bit is 1. The other bits are unchanged.
- R6: Word 5 is the read-write direction register, where 1 means output. `pin_oe` equals the direction register, and `pin_out` equals the output-data register.
- R7: A read of word 4 returns, for each pin, `pin_in` AND `pin_dig_en` as they stood two rising edges earlier. A pin that is not digitally enabled reads 0.
- R8: Reads of words 1, 2, 3, 6 and 7 return zero. Any read with `bus_re` low returns zero.
- R9: Writes to word 4 and to words 6 and 7 change neither the output-data nor the direction register. When `bus_we` is low, neither register changes.
- R10: Any mix of direct, set, clear and toggle writes leaves the output-data register equal to a bit-level reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data, zero when not reading |
| pin_out | output | 32 | Per-pin output level |
| pin_oe | output | 32 | Per-pin output enable |
| pin_in | input | 32 | Per-pin sampled level |
| pin_dig_en | input | 32 | Per-pin digital-input enable |

## Verification
The assertions assume that every bus input has a known value on each rising edge after reset, so comparisons against the previous cycle's write data are meaningful. They also assume that a write and a read never need an ordering between them inside one cycle. The bench drives all inputs from time zero, changes them only on falling edges, and issues each write as a single-cycle strobe. It samples the combinational read data off-edge while no write is pending. Pin inputs change only on falling edges, so the two-stage input lag lands on a known edge.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    WORD_OUT = 3'd0,
    WORD_SET = 3'd1,
    WORD_CLR = 3'd2,
    WORD_TOG = 3'd3,
    WORD_IN  = 3'd4,
    WORD_DIR = 3'd5
  } port_word_e;
endpackage

// File: rtl/port_out_regs.sv
module port_out_regs
  import pin_port_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] out_q_o,
  output logic [N_PINS-1:0] dir_q_o
);
  logic [N_PINS-1:0] out_q, out_d;
  logic [N_PINS-1:0] dir_q, dir_d;
  logic              out_en, dir_en;

  // next-state decode: one word per write, aliases act only on 1 bits
  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    out_en = 1'b0;
    dir_en = 1'b0;
    if (we) begin
      case (addr)
        WORD_OUT: begin out_d = wdata;           out_en = 1'b1; end
        WORD_SET: begin out_d = out_q | wdata;   out_en = 1'b1; end
        WORD_CLR: begin out_d = out_q & ~wdata;  out_en = 1'b1; end
        WORD_TOG: begin out_d = out_q ^ wdata;   out_en = 1'b1; end
        WORD_DIR: begin dir_d = wdata;           dir_en = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  assign out_q_o = out_q;
  assign dir_q_o = dir_q;

  AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == WORD_SET) |=> ((out_q & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == WORD_CLR) |=> ((out_q & $past(wdata)) == '0)); // R4
  AST_TOG_FLIPS_ONLY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == WORD_TOG) |=> ((out_q ^ $past(out_q)) == $past(wdata))); // R5
  AST_IGNORED_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || addr == WORD_IN || addr > WORD_DIR) |=> ($stable(out_q) && $stable(dir_q))); // R9
endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int N_PINS = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] raw_i,
  output logic [N_PINS-1:0] sync_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N_PINS-1:0] q;
    logic [N_PINS-1:0] d;
    if (s == 0) begin : g_first
      assign d = raw_i;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        q <= d;
      end
    end
  end

  assign sync_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/port_read_mux.sv
module port_read_mux
  import pin_port_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic [N_PINS-1:0] out_q,
  input  logic [N_PINS-1:0] dir_q,
  input  logic [N_PINS-1:0] in_q,
  output logic [N_PINS-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (re) begin
      case (addr)
        WORD_OUT: rdata = out_q;
        WORD_IN:  rdata = in_q;
        WORD_DIR: rdata = dir_q;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pin_port_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [N_PINS-1:0] bus_rdata,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_dig_en
);
  logic [N_PINS-1:0] out_q, dir_q, in_q;
  logic [N_PINS-1:0] in_gated;

  // pins without digital enable are masked before synchronizing
  assign in_gated = pin_in & pin_dig_en;

  port_out_regs #(.N_PINS(N_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .out_q_o (out_q),
    .dir_q_o (dir_q)
  );

  pin_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (in_gated),
    .sync_o (in_q)
  );

  port_read_mux #(.N_PINS(N_PINS)) u_rmux (
    .addr  (bus_addr),
    .re    (bus_re),
    .out_q (out_q),
    .dir_q (dir_q),
    .in_q  (in_q),
    .rdata (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == WORD_SET || bus_addr == WORD_CLR || bus_addr == WORD_TOG))
      |-> (bus_rdata == '0)); // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_re) |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/pin_port_ctrl_test.sv
`timescale 1ns/1ps
module pin_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [31:0] pin_out, pin_oe, pin_in, pin_dig_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] mdl;

  always #4 clk = ~clk;  // 125 MHz

  pin_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in), .pin_dig_en(pin_dig_en)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired: actual cycles %0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    bus_read(3'd0, r); check("R1 out reg", r, 32'h0);
    bus_read(3'd5, r); check("R1 dir reg", r, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] r;
    bus_write(3'd0, 32'hDEAD_BEEF);
    bus_read(3'd0, r); check("R2 out readback", r, 32'hDEAD_BEEF);
    check("R6 pin_out follows out reg", pin_out, 32'hDEAD_BEEF);
    bus_write(3'd0, 32'h0000_0000);
    bus_read(3'd0, r); check("R2 out reload zero", r, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] r;
    bus_write(3'd0, 32'h0F0F_0000);
    bus_write(3'd1, 32'h00FF_00F0);
    bus_read(3'd0, r); check("R3 set alias", r, 32'h0FFF_00F0);
  endtask

  task automatic t_clear();
    logic [31:0] r;
    bus_write(3'd0, 32'hFFFF_0F0F);
    bus_write(3'd2, 32'hF0F0_0F00);
    bus_read(3'd0, r); check("R4 clear alias", r, 32'h0F0F_000F);
  endtask

  task automatic t_toggle();
    logic [31:0] r;
    bus_write(3'd0, 32'hAAAA_5555);
    bus_write(3'd3, 32'hFF00_00FF);
    bus_read(3'd0, r); check("R5 toggle alias", r, 32'h55AA_55AA);
    bus_write(3'd3, 32'hFF00_00FF);
    bus_read(3'd0, r); check("R5 toggle twice restores", r, 32'hAAAA_5555);
  endtask

  task automatic t_direction();
    logic [31:0] r;
    bus_write(3'd5, 32'h1234_8765);
    bus_read(3'd5, r); check("R6 dir readback", r, 32'h1234_8765);
    check("R6 pin_oe follows dir", pin_oe, 32'h1234_8765);
  endtask

  task automatic t_input();
    logic [31:0] r;
    pin_dig_en = 32'hFFFF_FFFF;
    @(negedge clk); pin_in = 32'hA5A5_0F0F;
    @(posedge clk);
    @(negedge clk); bus_addr = 3'd4; bus_re = 1'b1; #1 r = bus_rdata; bus_re = 1'b0;
    check("R7 input after one edge still old", r, 32'h0);
    @(posedge clk);
    @(negedge clk); bus_addr = 3'd4; bus_re = 1'b1; #1 r = bus_rdata; bus_re = 1'b0;
    check("R7 input after two edges", r, 32'hA5A5_0F0F);
    @(negedge clk); pin_dig_en = 32'h0000_FFFF;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 3'd4; bus_re = 1'b1; #1 r = bus_rdata; bus_re = 1'b0;
    check("R7 disabled pins read zero", r, 32'h0000_0F0F);
  endtask

  task automatic t_alias_reads();
    logic [31:0] r;
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_read(3'd1, r); check("R8 set alias reads zero", r, 32'h0);
    bus_read(3'd2, r); check("R8 clear alias reads zero", r, 32'h0);
    bus_read(3'd3, r); check("R8 toggle alias reads zero", r, 32'h0);
    bus_read(3'd6, r); check("R8 word 6 reads zero", r, 32'h0);
    bus_read(3'd7, r); check("R8 word 7 reads zero", r, 32'h0);
    @(negedge clk); bus_addr = 3'd0; bus_re = 1'b0; #1 r = bus_rdata;
    check("R8 idle read zero", r, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] r;
    bus_write(3'd0, 32'h1234_5678);
    bus_write(3'd5, 32'hF0F0_F0F0);
    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_write(3'd6, 32'h0000_0000);
    bus_write(3'd7, 32'hFFFF_FFFF);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 32'h0; bus_we = 1'b0;
    @(negedge clk);
    bus_read(3'd0, r); check("R9 out unchanged", r, 32'h1234_5678);
    bus_read(3'd5, r); check("R9 dir unchanged", r, 32'hF0F0_F0F0);
    check("R9 pin_out unchanged", pin_out, 32'h1234_5678);
  endtask

  task automatic t_random();
    logic [31:0] r, d;
    logic [1:0]  op;
    bus_write(3'd0, 32'h0);
    mdl = 32'h0;
    for (int i = 0; i < 40; i++) begin
      op = 2'($urandom_range(0, 3));
      d  = $urandom;
      bus_write({1'b0, op}, d);
      case (op)
        2'd0: mdl = d;
        2'd1: mdl = mdl | d;
        2'd2: mdl = mdl & ~d;
        default: mdl = mdl ^ d;
      endcase
      bus_read(3'd0, r); check("R10 random sequence vs model", r, mdl);
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    pin_in = '0; pin_dig_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_set();
    t_clear();
    t_toggle();
    t_direction();
    t_input();
    t_alias_reads();
    t_ignored();
    t_random();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule